// File: doc/BRIEF.md
# Double-Precision Multiply Operand Screener

This block is the combinational front stage of a 64-bit binary floating-point multiplier. It looks at both operands together with an invalid-operation trap enable. It decides whether the product is settled by operand classes alone: a NaN, an infinity, a zero, or an invalid infinity-by-zero. In those cases it delivers the final 64-bit word, an invalid flag and a trap request.

Otherwise it marks the operation as ordinary. It then hands the downstream significand multiplier two 53-bit significands, each with its leading one in the top bit. A subnormal operand is normalized here, and the shift is folded into the exponent. The block also provides the signed, bias-corrected exponent sum.

NaN handling is deliberately lopsided. A signaling NaN in the first operand always wins. A quiet NaN in the first operand wins unless the second operand is signaling. The second operand's NaN is returned only when the first operand is not a NaN.

Top module: `fpm_front`

## Requirements
- R1: Every infinity or zero result carries sign bit 63 equal to the XOR of bit 63 of the two operands.
- R2: Infinity times zero, in either order, with the trap enable low, raises `invalid_o` and yields the default quiet NaN 0x7FF8000000000000.
- R3: Whenever an operation is invalid and the trap enable is high, `trap_o` is 1, `invalid_o` is 0 and `result_o` is all zeros.
- R4: If operand A is a signaling NaN, the result is A with fraction bit 51 set, and the operation is invalid whatever operand B holds. A signaling NaN has exponent bits 62:52 all ones, a nonzero fraction and bit 51 clear.
- R5: If A is a quiet NaN (exponent all ones, bit 51 set) and B is a signaling NaN, the result is B with bit 51 set, and the operation is invalid.
- R6: If A is a quiet NaN and B is not a signaling NaN, A is returned bit for bit and nothing is flagged.
- R7: If A is not a NaN and B is a NaN, B is returned with bit 51 set; the operation is invalid only when B was signaling.
- R8: Infinity times a nonzero non-NaN value, in either order, yields infinity (exponent all ones, fraction zero) with no flag.
- R9: Zero times any finite value yields a zero word (exponent and fraction zero) with no flag.
- R10: `pass_o` is 1 exactly when both operands are finite and nonzero, and `special_o` is always its complement; while `pass_o` is 0, both significand outputs and `exp_o` are zero.
- R11: For a normal operand on the ordinary path, the significand output is {1, fraction}. `exp_o` equals the sum of both operands' effective exponents minus 1023, where a normal operand's effective exponent is its biased exponent field.
- R12: A subnormal operand with L leading zeros in its 52-bit fraction yields the fraction shifted left by L+1 (top bit set) and contributes an effective exponent of -L.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a_i | input | 64 | First operand, binary64 |
| op_b_i | input | 64 | Second operand, binary64 |
| trap_en_i | input | 1 | Invalid-operation trap enable |
| special_o | output | 1 | Result is settled by this stage |
| pass_o | output | 1 | Ordinary operation, forward to multiplier |
| invalid_o | output | 1 | Invalid flag (untrapped) |
| trap_o | output | 1 | Invalid trap request |
| result_o | output | 64 | Final word for special cases, zero otherwise |
| sig_a_o | output | 53 | Normalized significand of A on pass |
| sig_b_o | output | 53 | Normalized significand of B on pass |
| exp_o | output | 13 | Signed exponent sum minus bias on pass |

## Verification
The checker takes the operands and the trap enable to be settled, known values whenever it samples. It therefore evaluates its properties as plain combinational relations, with no history. The bench changes inputs only just after a rising edge and reads outputs at the falling edge, so every comparison sees a stable input word. The stimulus mixes every class pair in both operand orders, with both trap settings. Subnormals are drawn over the whole range of leading-zero counts, so the normalization shift and the exponent correction are exercised at both ends.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
    parameter int EXP_W  = 11;
    parameter int FRAC_W = 52;

    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int SIG_W  = FRAC_W + 1;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int SUM_W  = EXP_W + 2;
    localparam int LZ_W   = $clog2(FRAC_W + 1);
    localparam int N_OPND = 2;

    typedef enum logic [2:0] {
        CL_ZERO, CL_SUB, CL_NORM, CL_INF, CL_QNAN, CL_SNAN
    } fp_class_e;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0] frac;
    } fp_word_t;

    typedef struct packed {
        fp_class_e cls;
        fp_word_t  word;
    } fp_info_t;

    function automatic fp_word_t make_quiet(input fp_word_t w);
        fp_word_t q;
        q = w;
        q.frac[FRAC_W-1] = 1'b1;
        return q;
    endfunction

    function automatic fp_word_t default_nan();
        fp_word_t q;
        q.sign = 1'b0;
        q.exp  = '1;
        q.frac = '0;
        q.frac[FRAC_W-1] = 1'b1;
        return q;
    endfunction

    function automatic logic is_nan(input fp_class_e c);
        return (c == CL_QNAN) || (c == CL_SNAN);
    endfunction

    function automatic logic [LZ_W-1:0] lead_zeros(input logic [FRAC_W-1:0] v);
        logic [LZ_W-1:0] n;
        n = LZ_W'(FRAC_W);
        for (int i = 0; i < FRAC_W; i++)
            if (v[i]) n = LZ_W'(FRAC_W - 1 - i);
        return n;
    endfunction
endpackage

// File: rtl/fpm_classify.sv
module fpm_classify
    import fpm_pkg::*;
(
    input  fp_word_t word_i,
    output fp_info_t info_o
);
    logic exp_ones, exp_zero, frac_zero;

    always_comb begin
        exp_ones  = &word_i.exp;
        exp_zero  = ~|word_i.exp;
        frac_zero = ~|word_i.frac;
        info_o.word = word_i;
        if (exp_ones && frac_zero)       info_o.cls = CL_INF;
        else if (exp_ones)               info_o.cls = word_i.frac[FRAC_W-1] ? CL_QNAN : CL_SNAN;
        else if (exp_zero && frac_zero)  info_o.cls = CL_ZERO;
        else if (exp_zero)               info_o.cls = CL_SUB;
        else                             info_o.cls = CL_NORM;
    end
endmodule

// File: rtl/fpm_align.sv
module fpm_align
    import fpm_pkg::*;
(
    input  fp_info_t                 info_i,
    output logic [SIG_W-1:0]         sig_o,
    output logic signed [SUM_W-1:0]  exp_o
);
    logic [LZ_W-1:0] lz;

    always_comb begin
        lz    = lead_zeros(info_i.word.frac);
        sig_o = '0;
        exp_o = '0;
        case (info_i.cls)
            CL_NORM: begin
                sig_o = {1'b1, info_i.word.frac};
                exp_o = $signed({{(SUM_W-EXP_W){1'b0}}, info_i.word.exp});
            end
            CL_SUB: begin
                sig_o = {1'b0, info_i.word.frac} << (lz + 1'b1);
                exp_o = -$signed({{(SUM_W-LZ_W){1'b0}}, lz});
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/fpm_resolve.sv
module fpm_resolve
    import fpm_pkg::*;
(
    input  fp_info_t a_i,
    input  fp_info_t b_i,
    input  logic     trap_en_i,
    output logic     special_o,
    output logic     invalid_o,
    output logic     trap_o,
    output fp_word_t result_o
);
    logic     bad, sgn, a_inf, b_inf, any_zero;
    fp_word_t res, inf_w, zero_w;

    always_comb begin
        sgn      = a_i.word.sign ^ b_i.word.sign;
        inf_w    = '{sign: sgn, exp: '1, frac: '0};
        zero_w   = '{sign: sgn, exp: '0, frac: '0};
        a_inf    = (a_i.cls == CL_INF);
        b_inf    = (b_i.cls == CL_INF);
        any_zero = (a_i.cls == CL_ZERO) || (b_i.cls == CL_ZERO);
        bad       = 1'b0;
        special_o = 1'b1;
        res       = '0;
        if (a_i.cls == CL_SNAN) begin
            bad = 1'b1;
            res = make_quiet(a_i.word);
        end else if (a_i.cls == CL_QNAN) begin
            if (b_i.cls == CL_SNAN) begin
                bad = 1'b1;
                res = make_quiet(b_i.word);
            end else begin
                res = a_i.word;
            end
        end else if (is_nan(b_i.cls)) begin
            bad = (b_i.cls == CL_SNAN);
            res = make_quiet(b_i.word);
        end else if (a_inf || b_inf) begin
            if (any_zero) begin
                bad = 1'b1;
                res = default_nan();
            end else begin
                res = inf_w;
            end
        end else if (any_zero) begin
            res = zero_w;
        end else begin
            special_o = 1'b0;
        end
        invalid_o = bad & ~trap_en_i;
        trap_o    = bad & trap_en_i;
        result_o  = trap_o ? '0 : res;
    end
endmodule

// File: rtl/fpm_front.sv
module fpm_front
    import fpm_pkg::*;
(
    input  logic                     [WORD_W-1:0] op_a_i,
    input  logic                     [WORD_W-1:0] op_b_i,
    input  logic                                  trap_en_i,
    output logic                                  special_o,
    output logic                                  pass_o,
    output logic                                  invalid_o,
    output logic                                  trap_o,
    output logic                     [WORD_W-1:0] result_o,
    output logic                     [SIG_W-1:0]  sig_a_o,
    output logic                     [SIG_W-1:0]  sig_b_o,
    output logic signed              [SUM_W-1:0]  exp_o
);
    localparam logic signed [SUM_W-1:0] BIAS_S = SUM_W'(BIAS);

    fp_word_t                 words [N_OPND];
    fp_info_t                 infos [N_OPND];
    logic [SIG_W-1:0]         sigs  [N_OPND];
    logic signed [SUM_W-1:0]  exps  [N_OPND];
    fp_word_t                 res_w;
    logic                     spec;

    assign words[0] = fp_word_t'(op_a_i);
    assign words[1] = fp_word_t'(op_b_i);

    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
        fpm_classify u_cls (.word_i(words[g]), .info_o(infos[g]));
        fpm_align    u_aln (.info_i(infos[g]), .sig_o(sigs[g]), .exp_o(exps[g]));
    end

    fpm_resolve u_res (
        .a_i       (infos[0]),
        .b_i       (infos[1]),
        .trap_en_i (trap_en_i),
        .special_o (spec),
        .invalid_o (invalid_o),
        .trap_o    (trap_o),
        .result_o  (res_w)
    );

    always_comb begin
        special_o = spec;
        pass_o    = ~spec;
        result_o  = res_w;
        sig_a_o   = pass_o ? sigs[0] : '0;
        sig_b_o   = pass_o ? sigs[1] : '0;
        exp_o     = pass_o ? (exps[0] + exps[1] - BIAS_S) : '0;
    end
endmodule

// File: rtl/fpm_front_chk.sv
module fpm_front_chk
    import fpm_pkg::*;
(
    input logic                        [WORD_W-1:0] op_a_i,
    input logic                        [WORD_W-1:0] op_b_i,
    input logic                                     special_o,
    input logic                                     pass_o,
    input logic                                     invalid_o,
    input logic                                     trap_o,
    input logic                        [WORD_W-1:0] result_o,
    input logic                        [SIG_W-1:0]  sig_a_o,
    input logic                        [SIG_W-1:0]  sig_b_o,
    input logic signed                 [SUM_W-1:0]  exp_o
);
    logic res_nan;
    assign res_nan = (&result_o[WORD_W-2 -: EXP_W]) && (|result_o[FRAC_W-1:0]);

    always_comb begin
        // R10
        pass_excl_chk: assert (pass_o ^ special_o);
        // R3
        trap_quiet_chk: assert (!trap_o || (!invalid_o && result_o == '0));
        // R2
        invalid_nan_chk: assert (!invalid_o || (res_nan && result_o[FRAC_W-1]));
        // R1
        sign_xor_chk: assert (!(special_o && !trap_o && !res_nan) ||
                              (result_o[WORD_W-1] == (op_a_i[WORD_W-1] ^ op_b_i[WORD_W-1])));
        // R12
        sig_lead_chk: assert (!pass_o || (sig_a_o[SIG_W-1] && sig_b_o[SIG_W-1]));
        // R10
        idle_zero_chk: assert (pass_o || (sig_a_o == '0 && sig_b_o == '0 && exp_o == '0));
    end
endmodule

bind fpm_front fpm_front_chk u_chk (
    .op_a_i    (op_a_i),
    .op_b_i    (op_b_i),
    .special_o (special_o),
    .pass_o    (pass_o),
    .invalid_o (invalid_o),
    .trap_o    (trap_o),
    .result_o  (result_o),
    .sig_a_o   (sig_a_o),
    .sig_b_o   (sig_b_o),
    .exp_o     (exp_o)
);

// File: tb/sim_fpm_front.sv
`timescale 1ns/1ps
module sim_fpm_front;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] a, b;
    logic        ten;
    logic        special_o, pass_o, invalid_o, trap_o;
    logic [63:0] result_o;
    logic [52:0] sig_a_o, sig_b_o;
    logic signed [12:0] exp_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    fpm_front u0 (
        .op_a_i(a), .op_b_i(b), .trap_en_i(ten),
        .special_o(special_o), .pass_o(pass_o), .invalid_o(invalid_o),
        .trap_o(trap_o), .result_o(result_o),
        .sig_a_o(sig_a_o), .sig_b_o(sig_b_o), .exp_o(exp_o)
    );

    localparam logic [63:0] QNAN_DEF = 64'h7FF8_0000_0000_0000;

    // class codes: 0 zero, 1 sub, 2 norm, 3 inf, 4 qnan, 5 snan
    function automatic int kind(input logic [63:0] w);
        if (w[62:52] == 11'h7FF) begin
            if (w[51:0] == 0) return 3;
            return w[51] ? 4 : 5;
        end
        if (w[62:52] == 0) return (w[51:0] == 0) ? 0 : 1;
        return 2;
    endfunction

    function automatic logic [63:0] quiet(input logic [63:0] w);
        return w | (64'd1 << 51);
    endfunction

    task automatic sig_of(input logic [63:0] w, output logic [52:0] s, output int e);
        int lz;
        if (w[62:52] != 0) begin
            s = {1'b1, w[51:0]};
            e = int'(w[62:52]);
        end else begin
            lz = 0;
            while (lz < 52 && w[51-lz] == 1'b0) lz++;
            s = 53'(w[51:0]) << (lz + 1);
            e = -lz;
        end
    endtask

    task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp_v);
        end
    endtask

    task automatic compare();
        int ka, kb, ea, eb;
        bit spec, bad;
        logic [63:0] r;
        logic [52:0] sa, sb;
        string tag;
        logic s;
        ka = kind(a); kb = kind(b);
        s  = a[63] ^ b[63];
        spec = 1; bad = 0; r = 0; tag = "R10";
        if (ka == 5) begin bad = 1; r = quiet(a); tag = "R4"; end
        else if (ka == 4 && kb == 5) begin bad = 1; r = quiet(b); tag = "R5"; end
        else if (ka == 4) begin r = a; tag = "R6"; end
        else if (kb >= 4) begin bad = (kb == 5); r = quiet(b); tag = "R7"; end
        else if ((ka == 3 || kb == 3) && (ka == 0 || kb == 0)) begin bad = 1; r = QNAN_DEF; tag = "R2"; end
        else if (ka == 3 || kb == 3) begin r = {s, 11'h7FF, 52'd0}; tag = "R8"; end
        else if (ka == 0 || kb == 0) begin r = {s, 63'd0}; tag = "R9"; end
        else spec = 0;
        if (bad && ten) begin r = 0; tag = "R3"; end
        check(tag, "special", 64'(special_o), 64'(spec));
        check("R10", "pass", 64'(pass_o), 64'(!spec));
        check(tag, "invalid", 64'(invalid_o), 64'(bad && !ten));
        check(tag, "trap", 64'(trap_o), 64'(bad && ten));
        check((tag == "R8" || tag == "R9") ? "R1" : tag, "result", result_o, r);
        if (spec) begin
            check("R10", "sig_a", 64'(sig_a_o), 0);
            check("R10", "exp", 64'(exp_o), 0);
        end else begin
            sig_of(a, sa, ea);
            sig_of(b, sb, eb);
            tag = (ka == 1 || kb == 1) ? "R12" : "R11";
            check(tag, "sig_a", 64'(sig_a_o), 64'(sa));
            check(tag, "sig_b", 64'(sig_b_o), 64'(sb));
            check(tag, "exp", 64'(int'(exp_o)), 64'(ea + eb - 1023));
        end
    endtask

    function automatic logic [63:0] mk(input int k);
        logic [51:0] f;
        logic sg;
        sg = 1'($urandom);
        f  = {20'($urandom), 32'($urandom)};
        case (k)
            0: return {sg, 63'd0};
            1: begin
                f = f >> ($urandom % 52);
                if (f == 0) f = 52'd1;
                return {sg, 11'd0, f};
            end
            2: return {sg, 11'(1 + $urandom % 2046), f};
            3: return {sg, 11'h7FF, 52'd0};
            4: return {sg, 11'h7FF, 1'b1, f[50:0]};
            default: begin
                if (f[50:0] == 0) f[0] = 1'b1;
                return {sg, 11'h7FF, 1'b0, f[50:0]};
            end
        endcase
    endfunction

    task automatic apply(input logic [63:0] x, input logic [63:0] y, input logic t);
        @(posedge clk);
        #0.5;
        a = x; b = y; ten = t;
        @(negedge clk);
        compare();
    endtask

    logic [63:0] qa[$];
    logic [63:0] qb[$];
    bit          qt[$];

    initial begin
        a = 0; b = 0; ten = 0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state: zero times zero is a plain zero, R9
        compare();
        // directed corners
        qa.push_back(64'h7FF0_0000_0000_0000); qb.push_back(64'h8000_0000_0000_0000); qt.push_back(0); // R2
        qa.push_back(64'h0000_0000_0000_0000); qb.push_back(64'hFFF0_0000_0000_0000); qt.push_back(0); // R2
        qa.push_back(64'h7FF0_0000_0000_0000); qb.push_back(64'h0000_0000_0000_0000); qt.push_back(1); // R3
        qa.push_back(64'hFFF0_0000_0000_0001); qb.push_back(64'h7FF8_0000_0000_0000); qt.push_back(0); // R4
        qa.push_back(64'h7FF8_0000_0000_0005); qb.push_back(64'hFFF0_0000_0000_0007); qt.push_back(0); // R5
        qa.push_back(64'hFFF8_0000_0000_0009); qb.push_back(64'h3FF0_0000_0000_0000); qt.push_back(0); // R6
        qa.push_back(64'h7FF0_0000_0000_0000); qb.push_back(64'h7FF0_0000_0000_0003); qt.push_back(0); // R7
        qa.push_back(64'hBFF0_0000_0000_0000); qb.push_back(64'h7FF0_0000_0000_0000); qt.push_back(0); // R8, R1
        qa.push_back(64'h8000_0000_0000_0000); qb.push_back(64'h4000_0000_0000_0000); qt.push_back(0); // R9, R1
        qa.push_back(64'h3FF0_0000_0000_0000); qb.push_back(64'h3FF8_0000_0000_0000); qt.push_back(0); // R11
        qa.push_back(64'h0000_0000_0000_0001); qb.push_back(64'h000F_FFFF_FFFF_FFFF); qt.push_back(0); // R12
        qa.push_back(64'h0008_0000_0000_0000); qb.push_back(64'h7FEF_FFFF_FFFF_FFFF); qt.push_back(0); // R12
        qa.push_back(64'h7FEF_FFFF_FFFF_FFFF); qb.push_back(64'h7FEF_FFFF_FFFF_FFFF); qt.push_back(1); // R11
        qa.push_back(64'h0000_0000_0000_0000); qb.push_back(64'h0000_0000_0000_0001); qt.push_back(0); // R9
        for (int i = 0; i < 3000; i++) begin
            qa.push_back(mk($urandom % 6));
            qb.push_back(mk($urandom % 6));
            qt.push_back(1'($urandom));
        end
        while (qa.size() > 0) apply(qa.pop_front(), qb.pop_front(), qt.pop_front());
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule